// File: doc/BRIEF.md
# Isolated I/O Port Decoder with Display Port

This block sits on the I/O side of an 8-bit processor bus where ports live in their own address space, separate from memory. It watches an 8-bit port number together with active-low read and write strobes. From these it keeps three write ports, one read port and a bank of eight chip selects. The write ports are a latch at one fully decoded port number, a latch that answers to a block of four aliased port numbers, and a latched seven-segment digit driver. The read port places a switch value on the data bus when the processor executes an input instruction to its port number.

All inputs are sampled on the system clock. During a write, the port number and data byte are held while the write strobe is low, and the selected port register loads them on the cycle after the strobe returns high. The fully decoded port and the aliased block share one port number. In that case the fully decoded port takes the write, the aliased latch keeps its value, and a debug output pulses for one cycle. The seven-segment driver can be built for common-anode parts (active-low segments) or common-cathode parts (active-high segments) through a parameter.

Top module: `ioport_decode`

## Requirements
- R1: After synchronous reset `out_port` and `alias_port` are 00H, `seg_out` shows every segment dark (FFH for common anode), `data_oe` is 0, `data_out` is 00H, `sel_n` is FFH and `overlap_dbg` is 0.
- R2: A write cycle to port 01H loads `data_in` into `out_port` one clock after `iow_n` rises. Any other port number, for example 81H, leaves `out_port` unchanged.
- R3: A write cycle to any port number whose upper six bits are 0 (00H, 01H, 02H, 03H) is a candidate for `alias_port`. The two low address bits are ignored. Port 04H does not touch it.
- R4: A write to 01H, where both decodes match, updates only `out_port`. `alias_port` keeps its value, and `overlap_dbg` is high for exactly one cycle, the same cycle in which `out_port` shows the new value.
- R5: While `ior_n` is low with port FFH on `addr`, `data_oe` is 1 and `data_out` equals `sw_in`, starting one clock after the condition is first sampled.
- R6: One clock after `ior_n` goes high, or when a read targets any port other than FFH, `data_oe` is 0 and `data_out` is 00H.
- R7: While either strobe is low and `addr[7:3]` equals 11110b (ports F0H–F7H), `sel_n[addr[2:0]]` is 0 and the other seven bits are 1, one clock after sampling. Outside that range all bits are 1.
- R8: A write to port FDH latches the byte for the display. Bit 0 drives segment A through bit 6 for segment G in `seg_out[6:0]`, and bit 7 drives the decimal point in `seg_out[7]`. With common anode the pins are inverted, so writing 66H gives 99H (segments B, C, F, G lit), 80H gives 7FH and 01H gives FEH.
- R9: A port register changes only on a rising edge of `iow_n`. A read cycle to 01H with data on `data_in` leaves `out_port` unchanged.
- R10: When both strobes are high, `sel_n` is FFH one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Port number presented during an I/O cycle |
| ior_n | input | 1 | Active-low I/O read strobe |
| iow_n | input | 1 | Active-low I/O write strobe |
| data_in | input | 8 | Data bus driven by the processor on writes |
| sw_in | input | 8 | Switch bank value for the read port |
| data_out | output | 8 | Value driven toward the data bus on reads |
| data_oe | output | 1 | Bus driver enable; 0 means released (high impedance) |
| sel_n | output | 8 | Active-low chip selects from the 3-to-8 stage |
| out_port | output | 8 | Latch at the fully decoded port 01H |
| alias_port | output | 8 | Latch for the aliased block 00H–03H |
| seg_out | output | 8 | Seven-segment pins, D7 on decimal point |
| overlap_dbg | output | 1 | One-cycle pulse when a write hits both decodes |

## Verification
The bench writes 01H and checks that only the fully decoded latch moves. A design that let the aliased port win, or let both ports load, would corrupt `alias_port` or miss the debug pulse. It writes 81H and 04H, so a decoder that drops the high address bits or ignores too many low bits would load a latch wrongly. It reads FEH and reads with the strobe released, which catches a bus driver that stays enabled or decodes only part of FFH. A read to 01H carrying bus data catches registers that load on any strobe. It also checks the display with 66H, 80H and 01H, so a reversed segment order or a missing inversion shows up as a wrong pin pattern.

// File: rtl/ioport_pkg.sv
package ioport_pkg;

  // Hits decoded from the held write-cycle port number
  typedef struct packed {
    logic abs_hit;    // fully decoded latch port
    logic alias_hit;  // aliased block
    logic seg_hit;    // display port
  } wr_hit_t;

  // Hits decoded from the live port number
  typedef struct packed {
    logic in_hit;     // switch read port
    logic dec_en;     // upper bits enable the select stage
  } rd_hit_t;

endpackage

// File: rtl/ioport_wr_match.sv
module ioport_wr_match
  import ioport_pkg::*;
#(
  parameter int              ADDR_W       = 8,
  parameter logic [ADDR_W-1:0] ABS_ADDR   = 8'h01,
  parameter logic [ADDR_W-1:0] ALIAS_BASE = 8'h00,
  parameter int              ALIAS_IGNORE = 2,
  parameter logic [ADDR_W-1:0] SEG_ADDR   = 8'hFD
) (
  input  logic [ADDR_W-1:0] addr,
  output wr_hit_t           hit
);

  localparam int KEEP_LO = ALIAS_IGNORE;

  always_comb begin
    hit.abs_hit   = (addr == ABS_ADDR);
    hit.alias_hit = (addr[ADDR_W-1:KEEP_LO] == ALIAS_BASE[ADDR_W-1:KEEP_LO]);
    hit.seg_hit   = (addr == SEG_ADDR);
  end

endmodule

// File: rtl/ioport_rd_match.sv
module ioport_rd_match
  import ioport_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                DEC_SEL_W = 3,
  parameter logic [ADDR_W-1:0] IN_ADDR   = 8'hFF,
  parameter logic [ADDR_W-DEC_SEL_W-1:0] DEC_HIGH = 5'b11110
) (
  input  logic [ADDR_W-1:0] addr,
  output rd_hit_t           hit
);

  always_comb begin
    hit.in_hit = (addr == IN_ADDR);
    hit.dec_en = (addr[ADDR_W-1:DEC_SEL_W] == DEC_HIGH);
  end

endmodule

// File: rtl/ioport_sel_decoder.sv
module ioport_sel_decoder #(
  parameter int SEL_W = 3,
  localparam int N_SEL = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [SEL_W-1:0] code,
  output logic [N_SEL-1:0] sel_n
);

  for (genvar i = 0; i < N_SEL; i++) begin : g_sel
    always_ff @(posedge clk) begin
      if (rst) sel_n[i] <= 1'b1;
      else     sel_n[i] <= !(en && (code == SEL_W'(i)));
    end
  end

endmodule

// File: rtl/ioport_port_latch.sv
module ioport_port_latch #(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  localparam logic [W-1:0] IDLE_VAL = INVERT ? '1 : '0;

  always_ff @(posedge clk) begin
    if (rst)     q <= IDLE_VAL;
    else if (we) q <= INVERT ? ~d : d;
  end

endmodule

// File: rtl/ioport_decode.sv
module ioport_decode
  import ioport_pkg::*;
#(
  parameter int                ADDR_W       = 8,
  parameter int                DATA_W       = 8,
  parameter int                DEC_SEL_W    = 3,
  parameter logic [ADDR_W-1:0] ABS_ADDR     = 8'h01,
  parameter logic [ADDR_W-1:0] ALIAS_BASE   = 8'h00,
  parameter int                ALIAS_IGNORE = 2,
  parameter logic [ADDR_W-1:0] SEG_ADDR     = 8'hFD,
  parameter logic [ADDR_W-1:0] IN_ADDR      = 8'hFF,
  parameter logic [ADDR_W-DEC_SEL_W-1:0] DEC_HIGH = 5'b11110,
  parameter bit                COMMON_ANODE = 1'b1,
  localparam int               N_SEL        = 1 << DEC_SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ior_n,
  input  logic              iow_n,
  input  logic [DATA_W-1:0] data_in,
  input  logic [DATA_W-1:0] sw_in,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic [N_SEL-1:0]  sel_n,
  output logic [DATA_W-1:0] out_port,
  output logic [DATA_W-1:0] alias_port,
  output logic [DATA_W-1:0] seg_out,
  output logic              overlap_dbg
);

  // Write-cycle capture: hold port number and data while the strobe is low
  logic              iow_q;
  logic [ADDR_W-1:0] hold_addr;
  logic [DATA_W-1:0] hold_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      iow_q     <= 1'b1;
      hold_addr <= '0;
      hold_data <= '0;
    end else begin
      iow_q <= iow_n;
      if (!iow_n) begin
        hold_addr <= addr;
        hold_data <= data_in;
      end
    end
  end

  logic commit;
  assign commit = iow_n && !iow_q;

  wr_hit_t wh;
  rd_hit_t rh;

  ioport_wr_match #(
    .ADDR_W(ADDR_W), .ABS_ADDR(ABS_ADDR), .ALIAS_BASE(ALIAS_BASE),
    .ALIAS_IGNORE(ALIAS_IGNORE), .SEG_ADDR(SEG_ADDR)
  ) u_wr_match (
    .addr(hold_addr),
    .hit (wh)
  );

  ioport_rd_match #(
    .ADDR_W(ADDR_W), .DEC_SEL_W(DEC_SEL_W), .IN_ADDR(IN_ADDR), .DEC_HIGH(DEC_HIGH)
  ) u_rd_match (
    .addr(addr),
    .hit (rh)
  );

  // Fixed priority: the fully decoded port wins over the aliased block
  logic abs_we, alias_we, seg_we;
  always_comb begin
    abs_we   = commit && wh.abs_hit;
    alias_we = commit && wh.alias_hit && !wh.abs_hit;
    seg_we   = commit && wh.seg_hit;
  end

  ioport_port_latch #(.W(DATA_W), .INVERT(1'b0)) u_abs_latch (
    .clk(clk), .rst(rst), .we(abs_we), .d(hold_data), .q(out_port)
  );

  ioport_port_latch #(.W(DATA_W), .INVERT(1'b0)) u_alias_latch (
    .clk(clk), .rst(rst), .we(alias_we), .d(hold_data), .q(alias_port)
  );

  ioport_port_latch #(.W(DATA_W), .INVERT(COMMON_ANODE)) u_seg_latch (
    .clk(clk), .rst(rst), .we(seg_we), .d(hold_data), .q(seg_out)
  );

  always_ff @(posedge clk) begin
    if (rst) overlap_dbg <= 1'b0;
    else     overlap_dbg <= commit && wh.abs_hit && wh.alias_hit;
  end

  // Read port: drive switches only during a read of the input port
  logic rd_sel;
  assign rd_sel = !ior_n && rh.in_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_oe  <= 1'b0;
      data_out <= '0;
    end else begin
      data_oe  <= rd_sel;
      data_out <= rd_sel ? sw_in : '0;
    end
  end

  // 3-to-8 select stage, enabled by the upper address bits and a strobe
  logic sel_en;
  assign sel_en = rh.dec_en && (!ior_n || !iow_n);

  ioport_sel_decoder #(.SEL_W(DEC_SEL_W)) u_sel_dec (
    .clk  (clk),
    .rst  (rst),
    .en   (sel_en),
    .code (addr[DEC_SEL_W-1:0]),
    .sel_n(sel_n)
  );

endmodule

// File: rtl/ioport_decode_chk.sv
module ioport_decode_chk #(
  parameter logic [7:0] IN_ADDR = 8'hFF
) (
  input logic       clk,
  input logic       rst,
  input logic [7:0] addr,
  input logic       ior_n,
  input logic       iow_n,
  input logic       data_oe,
  input logic [7:0] sel_n,
  input logic [7:0] out_port,
  input logic [7:0] alias_port,
  input logic [7:0] seg_out,
  input logic       overlap_dbg
);

  AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> $past(!ior_n && addr == IN_ADDR)); // R5

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~sel_n)); // R7

  AST_SEL_IDLE: assert property (@(posedge clk) disable iff (rst)
    (ior_n && iow_n) |=> (sel_n == 8'hFF)); // R10

  AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (rst)
    (iow_n && $past(iow_n)) |=>
      ($stable(out_port) && $stable(alias_port) && $stable(seg_out))); // R9

  AST_OVERLAP_ALIAS: assert property (@(posedge clk) disable iff (rst)
    overlap_dbg |-> $stable(alias_port)); // R4

endmodule

bind ioport_decode ioport_decode_chk #(.IN_ADDR(IN_ADDR)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .ior_n(ior_n), .iow_n(iow_n),
  .data_oe(data_oe), .sel_n(sel_n), .out_port(out_port),
  .alias_port(alias_port), .seg_out(seg_out), .overlap_dbg(overlap_dbg)
);

// File: tb/ioport_decode_test.sv
module ioport_decode_test;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] addr;
  logic       ior_n, iow_n;
  logic [7:0] data_in, sw_in;
  logic [7:0] data_out;
  logic       data_oe;
  logic [7:0] sel_n, out_port, alias_port, seg_out;
  logic       overlap_dbg;

  always #2 clk = ~clk;  // 250 MHz

  ioport_decode uut (
    .clk(clk), .rst(rst), .addr(addr), .ior_n(ior_n), .iow_n(iow_n),
    .data_in(data_in), .sw_in(sw_in), .data_out(data_out), .data_oe(data_oe),
    .sel_n(sel_n), .out_port(out_port), .alias_port(alias_port),
    .seg_out(seg_out), .overlap_dbg(overlap_dbg)
  );

  typedef struct {
    string      req;
    int         sig;   // 0 out,1 alias,2 seg,3 dout,4 oe,5 sel,6 overlap count
    logic [7:0] exp;
  } exp_t;

  exp_t q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  int   ov_cnt   = 0;
  bit   done     = 1'b0;

  function automatic logic [7:0] pick(int s);
    case (s)
      0: return out_port;
      1: return alias_port;
      2: return seg_out;
      3: return data_out;
      4: return {7'd0, data_oe};
      5: return sel_n;
      default: return 8'(ov_cnt);
    endcase
  endfunction

  // Monitor: count overlap pulses and drain the scoreboard away from the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst && overlap_dbg) ov_cnt++;
      while (q.size() > 0) begin
        exp_t e;
        logic [7:0] act;
        e = q.pop_front();
        act = pick(e.sig);
        n_checks++;
        if (act !== e.exp) begin
          n_fail++;
          $display("FAIL %s sig%0d actual=%02h expected=%02h", e.req, e.sig, act, e.exp);
        end
      end
    end
  end

  task automatic expect_val(string req, int sig, logic [7:0] v);
    exp_t e;
    e.req = req; e.sig = sig; e.exp = v;
    q.push_back(e);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic io_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; data_in = d; iow_n = 1'b0;
    idle(2);
    iow_n = 1'b1;
    idle(1);
    addr = 8'h55; data_in = 8'h00;
    idle(3);
  endtask

  initial begin
    rst = 1'b1; addr = 8'h00; ior_n = 1'b1; iow_n = 1'b1;
    data_in = 8'h00; sw_in = 8'h00;
    idle(4);
    rst = 1'b0;
    idle(2);

    // R1 reset state
    expect_val("R1", 0, 8'h00);
    expect_val("R1", 1, 8'h00);
    expect_val("R1", 2, 8'hFF);
    expect_val("R1", 3, 8'h00);
    expect_val("R1", 4, 8'h00);
    expect_val("R1", 5, 8'hFF);
    expect_val("R1", 6, 8'h00);
    idle(2);

    // R2 / R4 absolute port at 01H wins over alias block
    io_write(8'h01, 8'hA5);
    expect_val("R2", 0, 8'hA5);
    expect_val("R4", 1, 8'h00);
    expect_val("R4", 6, 8'h01);
    idle(2);

    // R2 non-matching high bit
    io_write(8'h81, 8'h3C);
    expect_val("R2", 0, 8'hA5);
    idle(2);

    // R3 aliased writes
    io_write(8'h00, 8'h11);
    expect_val("R3", 1, 8'h11);
    idle(2);
    io_write(8'h02, 8'h22);
    expect_val("R3", 1, 8'h22);
    idle(2);
    io_write(8'h03, 8'h33);
    expect_val("R3", 1, 8'h33);
    expect_val("R3", 0, 8'hA5);
    idle(2);
    io_write(8'h04, 8'h44);
    expect_val("R3", 1, 8'h33);
    expect_val("R4", 6, 8'h01);
    idle(2);

    // R8 display port
    io_write(8'hFD, 8'h66);
    expect_val("R8", 2, 8'h99);
    idle(2);
    io_write(8'hFD, 8'h80);
    expect_val("R8", 2, 8'h7F);
    idle(2);
    io_write(8'hFD, 8'h01);
    expect_val("R8", 2, 8'hFE);
    idle(2);

    // R5 read of switch port
    sw_in = 8'h5A;
    @(negedge clk);
    addr = 8'hFF; ior_n = 1'b0;
    idle(3);
    expect_val("R5", 4, 8'h01);
    expect_val("R5", 3, 8'h5A);
    idle(2);
    ior_n = 1'b1;
    idle(3);
    expect_val("R6", 4, 8'h00);
    expect_val("R6", 3, 8'h00);
    idle(2);

    // R6 read of a different port
    addr = 8'hFE; ior_n = 1'b0;
    idle(3);
    expect_val("R6", 4, 8'h00);
    expect_val("R6", 3, 8'h00);
    idle(2);
    ior_n = 1'b1;
    idle(2);

    // R9 read cycle to 01H with bus data does not latch
    addr = 8'h01; data_in = 8'hEE; ior_n = 1'b0;
    idle(3);
    ior_n = 1'b1;
    idle(3);
    expect_val("R9", 0, 8'hA5);
    expect_val("R9", 1, 8'h33);
    idle(2);

    // R7 select stage
    addr = 8'hF3; iow_n = 1'b0;
    idle(3);
    expect_val("R7", 5, 8'hF7);
    idle(2);
    iow_n = 1'b1;
    idle(3);
    expect_val("R10", 5, 8'hFF);
    idle(2);
    addr = 8'hF6; ior_n = 1'b0;
    idle(3);
    expect_val("R7", 5, 8'hBF);
    idle(2);
    addr = 8'hE6;
    idle(3);
    expect_val("R7", 5, 8'hFF);
    idle(2);
    ior_n = 1'b1;
    idle(3);
    expect_val("R10", 5, 8'hFF);
    expect_val("R9", 0, 8'hA5);
    idle(3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule